// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between several hardware contexts and a shared memory port and decides which stores reach memory. A load-linked request leaves a reservation: the request address with its low bits cleared to a 16-byte block boundary, tagged with the requesting context's ID. The table holds a few such reservations.

Every store is checked against the table. An ordinary store is always allowed to write, and it removes any reservation on the same 16-byte block. A store-conditional may write only if its own context holds a reservation on that block. The requester learns the outcome through a result bit, which is 1 on success and 0 on failure. A failed store-conditional has its write suppressed.

The table keeps its entries in age order. A context that issues a new load-linked drops its earlier reservation. When the table is full, a new reservation pushes out the oldest one. The write gate and the conditional result are registered, so they appear one cycle after the request. The memory array and the data path are outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: A synchronous reset clears every reservation and drives `wr_en`, `sc_done` and `sc_result` low. A store-conditional issued after reset fails, even if its block was reserved before reset.
- R2: Address bits below the 16-byte boundary (bits 3..0) are ignored. A load-linked at 0x103 and a store-conditional at 0x10C from the same context match.
- R3: A store-conditional whose context holds a reservation on its block succeeds: `wr_en`=1, `sc_done`=1, `sc_result`=1.
- R4: A store-conditional issued when no reservation exists fails: `wr_en`=0, `sc_done`=1, `sc_result`=0.
- R5: An ordinary store (`req_kind`=2'b10) always gives `wr_en`=1 and `sc_done`=0, whether or not the table is empty.
- R6: An ordinary store removes every reservation on its block, so a later store-conditional to that block fails.
- R7: A store-conditional from a context that holds no reservation on the block fails and leaves the table unchanged. The reserving context's store-conditional still succeeds afterwards.
- R8: A successful store-conditional removes every reservation on its block, including those of other contexts.
- R9: A load-linked replaces any earlier reservation of the same context. The old block then fails a store-conditional and the new block succeeds.
- R10: With `ENTRIES` reservations held, a load-linked from a new context evicts the oldest reservation. That reservation's store-conditional fails, while the next-oldest reservation still succeeds.
- R11: Outputs appear exactly one cycle after an accepted request and last one cycle. A cycle with `req_valid`=0 yields `wr_en`=0 and `sc_done`=0 in the following cycle.
- R12: A plain load (`req_kind`=2'b00) and a load-linked (2'b01) never raise `wr_en` or `sc_done`. A plain load leaves the reservations untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 load, 01 load-linked, 10 store, 11 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting context ID |
| wr_en | output | 1 | Store may write memory (registered) |
| sc_done | output | 1 | A store-conditional result is reported this cycle |
| sc_result | output | 1 | 1 = store-conditional succeeded, 0 = failed |

## Verification
The store-conditional check is tried against five kinds of table state:
- an empty table, which separates the fast-fail path from the search;
- a same-context hit at a different byte offset, which shows that the low bits are masked;
- a wrong-context hit, which shows that the context must match and that a failure leaves the table unchanged;
- a reservation already removed by a plain store or by a competing successful store-conditional, which shows that every writing store clears the block;
- a reservation lost through replacement or through eviction from a full table, which separates the same-context replacement rule from the oldest-first eviction order.

Idle cycles and plain loads placed between requests show that the outputs are single-cycle pulses and that loads have no effect.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 3,
  parameter int ENTRIES   = 4,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              wr_en,
  output logic              sc_done,
  output logic              sc_result
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'((1 << GRAN_BITS) - 1);

  logic [ADDR_W-1:0] blk_q [ENTRIES];
  logic [CTX_W-1:0]  ctx_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ADDR_W-1:0] blk_c [ENTRIES];
  logic [CTX_W-1:0]  ctx_c [ENTRIES];
  logic [ENTRIES-1:0] vld_c;

  logic [ENTRIES-1:0] hit, own, keep;
  logic [ADDR_W-1:0] req_blk;
  logic is_ll, is_st, is_sc, tbl_empty, sc_ok, do_write;

  assign req_blk   = req_addr & ~LOW;
  assign is_ll     = req_valid && req_kind == 2'b01;
  assign is_st     = req_valid && req_kind == 2'b10;
  assign is_sc     = req_valid && req_kind == 2'b11;
  assign tbl_empty = ~|vld_q;
  assign sc_ok     = !tbl_empty && |own;
  assign do_write  = is_st || (is_sc && sc_ok);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i]  = vld_q[i] && blk_q[i] == req_blk;
    assign own[i]  = hit[i] && ctx_q[i] == req_ctx;
    assign keep[i] = vld_q[i] && !(is_ll && ctx_q[i] == req_ctx) && !(do_write && hit[i]);
  end

  always_comb begin
    int k;
    k = 0;
    vld_c = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      blk_c[i] = '0;
      ctx_c[i] = '0;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (keep[i]) begin
        blk_c[k[IDX_W-1:0]] = blk_q[i];
        ctx_c[k[IDX_W-1:0]] = ctx_q[i];
        vld_c[k[IDX_W-1:0]] = 1'b1;
        k = k + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        blk_q[i] <= '0;
        ctx_q[i] <= '0;
      end
    end else if (is_ll) begin
      blk_q[0] <= req_blk;
      ctx_q[0] <= req_ctx;
      vld_q[0] <= 1'b1;
      for (int i = 1; i < ENTRIES; i++) begin
        blk_q[i] <= blk_c[i-1];
        ctx_q[i] <= ctx_c[i-1];
        vld_q[i] <= vld_c[i-1];
      end
    end else begin
      blk_q <= blk_c;
      ctx_q <= ctx_c;
      vld_q <= vld_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      sc_done   <= 1'b0;
      sc_result <= 1'b0;
    end else begin
      wr_en     <= do_write;
      sc_done   <= is_sc;
      sc_result <= is_sc && sc_ok;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic [ENTRIES-1:0] vld,
  input logic               wr_en,
  input logic               sc_done,
  input logic               sc_result
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wr_en && !sc_done && !sc_result && vld == '0));

  p_sc_writes_on_success_r3: assert property (@(posedge clk) disable iff (rst)
    sc_done |-> (wr_en == sc_result));

  p_empty_sc_fails_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b11 && vld == '0) |=> (sc_done && !sc_result && !wr_en));

  p_store_writes_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b10) |=> (wr_en && !sc_done));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!wr_en && !sc_done));

  p_result_needs_sc_r11: assert property (@(posedge clk) disable iff (rst)
    sc_result |-> sc_done);

  p_loads_no_write_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_kind[1]) |=> (!wr_en && !sc_done));

  p_load_keeps_table_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00) |=> $stable(vld));
endmodule

bind llsc_monitor llsc_monitor_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .vld(vld_q), .wr_en(wr_en), .sc_done(sc_done), .sc_result(sc_result)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int ADDR_W = 32;
  localparam int CTX_W  = 3;
  localparam logic [1:0] LD = 2'b00, LL = 2'b01, ST = 2'b10, SC = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic wr_en, sc_done, sc_result;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic  wr;
    logic  done;
    logic  res;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .CTX_W(CTX_W), .ENTRIES(4), .GRAN_BITS(4)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ctx(req_ctx),
    .wr_en(wr_en), .sc_done(sc_done), .sc_result(sc_result)
  );

  task automatic send(input logic v, input logic [1:0] k, input logic [ADDR_W-1:0] a,
                      input logic [CTX_W-1:0] c, input logic ew, input logic ed,
                      input logic er, input string r);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_kind = k; req_addr = a; req_ctx = c;
    @(posedge clk);
    e.wr = ew; e.done = ed; e.res = er; e.req = r;
    q.push_back(e);
  endtask

  task automatic idle(input string r);
    send(1'b0, LD, '0, '0, 1'b0, 1'b0, 1'b0, r);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({wr_en, sc_done, sc_result} !== {e.wr, e.done, e.res}) begin
        fails++;
        $display("FAIL %s: got wr/done/res=%b%b%b expected %b%b%b",
                 e.req, wr_en, sc_done, sc_result, e.wr, e.done, e.res);
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if ({wr_en, sc_done, sc_result} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset outputs: got %b%b%b expected 000", wr_en, sc_done, sc_result);
    end
    idle("R11 idle after reset");
    send(1, SC, 32'h100, 3'd0, 0, 1, 0, "R4 sc on empty table");
    send(1, ST, 32'h200, 3'd1, 1, 0, 0, "R5 store on empty table");
    idle("R11 store pulse ends");
    send(1, LL, 32'h103, 3'd0, 0, 0, 0, "R12 load-linked no write");
    send(1, LD, 32'h100, 3'd0, 0, 0, 0, "R12 plain load no write");
    send(1, SC, 32'h10C, 3'd0, 1, 1, 1, "R2 R3 masked sc success");
    send(1, SC, 32'h100, 3'd0, 0, 1, 0, "R8 reservation consumed");
    send(1, LL, 32'h300, 3'd1, 0, 0, 0, "R8 ll ctx1");
    send(1, LL, 32'h305, 3'd2, 0, 0, 0, "R8 ll ctx2");
    send(1, SC, 32'h300, 3'd1, 1, 1, 1, "R8 ctx1 sc wins");
    send(1, SC, 32'h300, 3'd2, 0, 1, 0, "R8 ctx2 sc loses");
    send(1, LL, 32'h400, 3'd3, 0, 0, 0, "R7 ll ctx3");
    send(1, ST, 32'h1F0, 3'd4, 1, 0, 0, "R5 store with table not empty");
    send(1, SC, 32'h400, 3'd2, 0, 1, 0, "R7 wrong context fails");
    send(1, SC, 32'h40F, 3'd3, 1, 1, 1, "R7 owner still succeeds");
    send(1, LL, 32'h500, 3'd0, 0, 0, 0, "R6 ll ctx0");
    send(1, ST, 32'h508, 3'd5, 1, 0, 0, "R6 plain store");
    send(1, SC, 32'h500, 3'd0, 0, 1, 0, "R6 sc after store fails");
    send(1, LL, 32'h600, 3'd1, 0, 0, 0, "R9 first ll");
    send(1, LL, 32'h700, 3'd1, 0, 0, 0, "R9 second ll");
    send(1, SC, 32'h600, 3'd1, 0, 1, 0, "R9 replaced block fails");
    send(1, SC, 32'h700, 3'd1, 1, 1, 1, "R9 new block succeeds");
    for (int i = 0; i < 5; i++)
      send(1, LL, 32'h1000 + 32'(i) * 32'h100, 3'(i), 0, 0, 0, "R10 fill table");
    send(1, SC, 32'h1000, 3'd0, 0, 1, 0, "R10 oldest evicted");
    send(1, SC, 32'h1100, 3'd1, 1, 1, 1, "R10 next oldest kept");
    idle("R11 idle");
    send(1, LL, 32'h800, 3'd2, 0, 0, 0, "R1 ll before reset");
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    send(1, SC, 32'h800, 3'd2, 0, 1, 0, "R1 reservation cleared by reset");
    idle("R11 final idle");
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule